// File: doc/BRIEF.md
# I2C Serial Memory Slave Front End

This block is the bus-facing half of a small serial non-volatile memory. It watches the two-wire bus on its own system clock, finds start and stop conditions, and decodes the first byte of every transfer. That byte carries a 4-bit device type code, two select bits that must equal the strap inputs, a block-select bit and a direction bit. When the byte matches, the slave acknowledges it. It then either accepts and acknowledges data bytes from the master, or streams bytes from the storage side until the master declines one.

Toward storage it offers a simple byte handshake. Received bytes appear with a one-cycle valid pulse. Bytes to send are read from an input that the storage side holds stable, and a one-cycle take strobe marks each load. The latched block-select bit is an output. A one-cycle commit strobe tells storage to begin its non-volatile write cycle when a write transfer that carried data ends with a stop.

SDA is open drain: the block only drives the line low or leaves it released.

Top module: `i2c_nvm_slave`

## Requirements
- R1: After reset `sda_drive_low`, `wr_valid`, `rd_take` and `commit_pulse` are all 0.
- R2: A stop (SDA rising while SCL is high) returns the block to idle and releases SDA from any state.
- R3: The first byte after a start is taken MSB first. Bits [7:4] are the type code, bits [3:2] are the select bits, bit [1] is block select and bit [0] is the direction. When bits [7:4] equal 4'b1010 and bits [3:2] equal `strap_sel`, SDA is held low during the ninth SCL high period.
- R4: If either the type code or the select bits differ, the block never drives SDA and raises no strobe until the next start.
- R5: The drive-low enable changes only while SCL is low.
- R6: In a write transfer (bit [0] = 0) each 8-bit data byte appears on `wr_data` with a one-cycle `wr_valid` pulse and is acknowledged in its ninth clock.
- R7: `blk_sel` holds bit [1] of the last accepted address byte.
- R8: In a read transfer (bit [0] = 1) the block sends `rd_data` MSB first. It pulses `rd_take` once for each byte it loads, and loads the next byte after each master acknowledge.
- R9: When the master leaves SDA high in the ninth clock of a read byte, no further byte is loaded and SDA stays released.
- R10: A stop pulses `commit_pulse` for one cycle only when at least one write data byte was received since the last start. A read, an address-only write or a mismatched address gives no pulse.
- R11: A start seen in the middle of a transfer, including partway through a byte, discards the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_sel | input | 2 | Device select straps |
| wr_data | output | 8 | Last received write data byte |
| wr_valid | output | 1 | One-cycle pulse when `wr_data` is new |
| rd_data | input | 8 | Next byte to transmit, held by storage |
| rd_take | output | 1 | One-cycle pulse when `rd_data` is loaded |
| blk_sel | output | 1 | Block-select bit of the accepted address |
| commit_pulse | output | 1 | One-cycle write-cycle start strobe |

## Verification
The assertions assume the bus obeys the protocol relative to the system clock. SCL must stay in each level for several more system cycles than the synchronizer latency. SDA from the master may change only well inside an SCL low period, except for deliberate start and stop edges. Under these conditions the drive-enable check holds, and the slave's own SDA changes never look like bus conditions. The bench master keeps every SCL phase at least eight system cycles long and moves SDA a quarter period after the SCL edge. It models the line as the wired AND of the master and the slave.

// File: rtl/i2c_nvm_pkg.sv
package i2c_nvm_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_ACK   = 3'd2,
      ST_WR    = 3'd3,
      ST_RD    = 3'd4,
      ST_RDACK = 3'd5,
      ST_SKIP  = 3'd6
   } nvm_state_t;
endpackage

// File: rtl/i2c_nvm_sync.sv
module i2c_nvm_sync #(
   parameter int         W       = 2,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("sync needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_nvm_cond.sv
module i2c_nvm_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_nvm_core.sv
module i2c_nvm_core
   import i2c_nvm_pkg::*;
#(
   parameter int           TYPE_W   = 4,
   parameter int           SEL_W    = 2,
   parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [SEL_W-1:0]  strap_sel,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_drive_low,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_valid,
   output logic              rd_take,
   output logic              blk_sel,
   output logic              commit_pulse
);
   localparam int CNT_W   = $clog2(BYTE_W);
   localparam int TYPE_HI = BYTE_W - 1;
   localparam int SEL_HI  = BYTE_W - 1 - TYPE_W;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   nvm_state_t        state;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              phase;
   logic              rd_dir;
   logic              data_seen;
   logic [BYTE_W-1:0] next_byte;
   logic              addr_hit;

   assign next_byte = {shreg[BYTE_W-2:0], sda_s};
   assign addr_hit  = (next_byte[TYPE_HI -: TYPE_W] == DEV_TYPE) &&
                      (next_byte[SEL_HI  -: SEL_W]  == strap_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         shreg         <= '0;
         bit_cnt       <= '0;
         phase         <= 1'b0;
         rd_dir        <= 1'b0;
         data_seen     <= 1'b0;
         sda_drive_low <= 1'b0;
         wr_data       <= '0;
         wr_valid      <= 1'b0;
         rd_take       <= 1'b0;
         blk_sel       <= 1'b0;
         commit_pulse  <= 1'b0;
      end else begin
         wr_valid     <= 1'b0;
         rd_take      <= 1'b0;
         commit_pulse <= 1'b0;
         if (stop_det) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
            commit_pulse  <= data_seen;
            data_seen     <= 1'b0;
         end else if (start_det) begin
            state         <= ST_ADDR;
            bit_cnt       <= '0;
            phase         <= 1'b0;
            sda_drive_low <= 1'b0;
            data_seen     <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: if (scl_rise) begin
                  shreg   <= next_byte;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == LAST_BIT) begin
                     if (addr_hit) begin
                        state   <= ST_ACK;
                        phase   <= 1'b0;
                        rd_dir  <= next_byte[0];
                        blk_sel <= next_byte[1];
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: if (scl_fall) begin
                  if (!phase) begin
                     sda_drive_low <= 1'b1;
                     phase         <= 1'b1;
                  end else begin
                     phase   <= 1'b0;
                     bit_cnt <= '0;
                     if (rd_dir) begin
                        shreg         <= rd_data;
                        sda_drive_low <= ~rd_data[BYTE_W-1];
                        rd_take       <= 1'b1;
                        state         <= ST_RD;
                     end else begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_WR;
                     end
                  end
               end
               ST_WR: if (scl_rise) begin
                  shreg   <= next_byte;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == LAST_BIT) begin
                     wr_data   <= next_byte;
                     wr_valid  <= 1'b1;
                     data_seen <= 1'b1;
                     phase     <= 1'b0;
                     state     <= ST_ACK;
                  end
               end
               ST_RD: if (scl_fall) begin
                  if (bit_cnt == LAST_BIT) begin
                     sda_drive_low <= 1'b0;
                     phase         <= 1'b0;
                     state         <= ST_RDACK;
                  end else begin
                     shreg         <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_drive_low <= ~shreg[BYTE_W-2];
                     bit_cnt       <= bit_cnt + 1'b1;
                  end
               end
               ST_RDACK: begin
                  if (scl_rise) begin
                     if (sda_s) state <= ST_SKIP;
                     else       phase <= 1'b1;
                  end else if (scl_fall && phase) begin
                     phase         <= 1'b0;
                     bit_cnt       <= '0;
                     shreg         <= rd_data;
                     sda_drive_low <= ~rd_data[BYTE_W-1];
                     rd_take       <= 1'b1;
                     state         <= ST_RD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_drive_low && state == ST_IDLE)); // R2
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !$past(scl_s)); // R5
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!sda_drive_low && !wr_valid && !rd_take)); // R4
   AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> $past(stop_det)); // R10
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_valid, rd_take, commit_pulse})); // R6
   AST_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !rd_dir); // R6
   AST_TAKE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> rd_dir); // R8
   AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (state == ST_ADDR && !sda_drive_low)); // R11
endmodule

// File: rtl/i2c_nvm_slave.sv
module i2c_nvm_slave
   import i2c_nvm_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                TYPE_W      = 4,
   parameter int                SEL_W       = 2,
   parameter logic [TYPE_W-1:0] DEV_TYPE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low,
   input  logic [SEL_W-1:0]  strap_sel,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_valid,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              rd_take,
   output logic              blk_sel,
   output logic              commit_pulse
);
   localparam int ADDR_FIELDS = TYPE_W + SEL_W + 2;

   initial begin
      assert (ADDR_FIELDS == BYTE_W) else $error("address fields must fill one byte");
      assert (SEL_W >= 1) else $error("need at least one select bit");
   end

   logic [1:0] bus_s;
   logic       scl_rise, scl_fall, start_det, stop_det;

   i2c_nvm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   i2c_nvm_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_nvm_core #(.TYPE_W(TYPE_W), .SEL_W(SEL_W), .DEV_TYPE(DEV_TYPE)) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_s         (bus_s[1]),
      .sda_s         (bus_s[0]),
      .scl_rise      (scl_rise),
      .scl_fall      (scl_fall),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .strap_sel     (strap_sel),
      .rd_data       (rd_data),
      .sda_drive_low (sda_drive_low),
      .wr_data       (wr_data),
      .wr_valid      (wr_valid),
      .rd_take       (rd_take),
      .blk_sel       (blk_sel),
      .commit_pulse  (commit_pulse)
   );
endmodule

// File: tb/test_i2c_nvm_slave.sv
module test_i2c_nvm_slave;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 8;
   localparam int HALF       = 2 * QTR;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       msda = 1'b1;
   logic       sda_line;
   logic       sda_drive_low;
   logic [1:0] strap_sel = 2'b01;
   logic [7:0] wr_data;
   logic       wr_valid;
   logic [7:0] rd_data;
   logic       rd_take;
   logic       blk_sel;
   logic       commit_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int n_commit = 0;
   int n_take   = 0;
   int n_oe_bad = 0;
   bit done     = 1'b0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = msda & ~sda_drive_low;

   i2c_nvm_slave i_i2c_nvm_slave (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .sda_drive_low (sda_drive_low),
      .strap_sel     (strap_sel),
      .wr_data       (wr_data),
      .wr_valid      (wr_valid),
      .rd_data       (rd_data),
      .rd_take       (rd_take),
      .blk_sel       (blk_sel),
      .commit_pulse  (commit_pulse)
   );

   // storage model: advance to the next byte after each take
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= 8'h3C;
      else if (rd_take) rd_data <= rd_data + 8'h11;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard for write bytes, strobe counts, SDA-change rule
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected byte", wr_data, 0);
            else begin
               automatic logic [7:0] e = exp_q.pop_front();
               check(wr_data == e, "R6 write byte", wr_data, e);
            end
         end
         if (commit_pulse) n_commit++;
         if (rd_take) n_take++;
         if (scl && scl_prev && (sda_drive_low != oe_prev)) n_oe_bad++;
      end
      scl_prev = scl;
      oe_prev  = sda_drive_low;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      if (!scl) begin
         wait_clk(QTR); msda = 1'b1;
         wait_clk(QTR); scl = 1'b1;
         wait_clk(QTR);
      end
      msda = 1'b0;
      wait_clk(QTR); scl = 1'b0;
   endtask

   task automatic do_stop();
      wait_clk(QTR); msda = 1'b0;
      wait_clk(QTR); scl = 1'b1;
      wait_clk(QTR); msda = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         wait_clk(QTR); msda = b[7-i];
         wait_clk(QTR); scl = 1'b1;
         wait_clk(HALF); scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit push, output bit ack);
      if (push) exp_q.push_back(b);
      send_bits(b, 8);
      wait_clk(QTR); msda = 1'b1;
      wait_clk(QTR); scl = 1'b1;
      wait_clk(QTR); ack = (sda_line == 1'b0);
      wait_clk(QTR); scl = 1'b0;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] b);
      msda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         wait_clk(HALF); scl = 1'b1;
         wait_clk(QTR); b[7-i] = sda_line;
         wait_clk(QTR); scl = 1'b0;
      end
      wait_clk(QTR); msda = give_ack ? 1'b0 : 1'b1;
      wait_clk(QTR); scl = 1'b1;
      wait_clk(HALF); scl = 1'b0;
      wait_clk(QTR); msda = 1'b1;
   endtask

   initial begin
      wait_clk(150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] rb;
      logic [7:0] exp_rd;
      int         c0, t0;

      wait_clk(5);
      // R1 reset state
      check(sda_drive_low == 1'b0, "R1 drive", sda_drive_low, 0);
      check(wr_valid == 1'b0 && commit_pulse == 1'b0, "R1 strobes", {wr_valid, commit_pulse}, 0);
      rst_n = 1'b1;
      wait_clk(10);

      // write with block 1 to straps 01: addr A6
      do_start();
      send_byte(8'hA6, 1'b0, ack);
      check(ack, "R3 address ack", ack, 1);
      check(blk_sel == 1'b1, "R7 block bit", blk_sel, 1);
      send_byte(8'h5A, 1'b1, ack);
      check(ack, "R6 data ack", ack, 1);
      send_byte(8'hC3, 1'b1, ack);
      check(ack, "R6 data ack 2", ack, 1);
      c0 = n_commit;
      do_stop();
      check(n_commit == c0 + 1, "R10 commit after write", n_commit - c0, 1);
      check(sda_drive_low == 1'b0, "R2 released after stop", sda_drive_low, 0);

      // wrong type code
      do_start();
      send_byte(8'hB6, 1'b0, ack);
      check(!ack, "R4 type mismatch", ack, 0);
      send_byte(8'h77, 1'b0, ack);
      check(!ack, "R4 ignored byte", ack, 0);
      c0 = n_commit;
      do_stop();
      check(n_commit == c0, "R10 no commit on mismatch", n_commit - c0, 0);

      // wrong select bits
      do_start();
      send_byte(8'hAE, 1'b0, ack);
      check(!ack, "R4 select mismatch", ack, 0);
      do_stop();

      // read three bytes, straps 01, block 0: addr A5
      exp_rd = 8'h3C;
      t0 = n_take;
      do_start();
      send_byte(8'hA5, 1'b0, ack);
      check(ack, "R3 read address ack", ack, 1);
      check(blk_sel == 1'b0, "R7 block bit clear", blk_sel, 0);
      for (int k = 0; k < 3; k++) begin
         read_byte(k != 2, rb);
         check(rb == exp_rd, "R8 read byte", rb, exp_rd);
         exp_rd = exp_rd + 8'h11;
      end
      wait_clk(HALF);
      check(n_take - t0 == 3, "R9 no load after nack", n_take - t0, 3);
      check(sda_drive_low == 1'b0, "R9 released after nack", sda_drive_low, 0);
      c0 = n_commit;
      do_stop();
      check(n_commit == c0, "R10 no commit on read", n_commit - c0, 0);

      // repeated start between bytes, then mid-byte
      strap_sel = 2'b10;
      do_start();
      send_byte(8'hAA, 1'b0, ack);
      check(ack, "R3 straps 10", ack, 1);
      send_byte(8'h11, 1'b1, ack);
      do_start();
      send_byte(8'hA8, 1'b0, ack);
      check(ack, "R11 ack after restart", ack, 1);
      check(blk_sel == 1'b0, "R7 block after restart", blk_sel, 0);
      send_bits(8'hF0, 4);
      do_start();
      send_byte(8'hAA, 1'b0, ack);
      check(ack, "R11 ack after mid-byte restart", ack, 1);
      send_byte(8'h33, 1'b1, ack);
      c0 = n_commit;
      do_stop();
      check(n_commit == c0 + 1, "R10 commit after restart", n_commit - c0, 1);

      // address-only write
      do_start();
      send_byte(8'hA8, 1'b0, ack);
      c0 = n_commit;
      do_stop();
      check(n_commit == c0, "R10 no commit address only", n_commit - c0, 0);

      wait_clk(HALF);
      check(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);
      check(n_oe_bad == 0, "R5 SDA change during SCL high", n_oe_bad, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule